// File: doc/BRIEF.md
# Flash program/erase fault guard

This block sits between the CPU register bus and an embedded flash macro. It holds the program, erase, program-verify and erase-verify control bits, plus a per-block erase enable register. From these it drives the enable lines of the flash macro. While a program or erase run is in progress, it watches strobes from the CPU core and the bus arbiter for abnormal behaviour. Examples are a read of the flash range being worked on, an exception, a sleep, or a bus handover.

On any such event the run is aborted in the same cycle and a sticky fault flag is raised. While the flag is up, program and erase cannot be started again, but both verify modes remain reachable so software can inspect the damage. The fault is cleared only by the pin reset, a watchdog reset or hardware standby. Software standby during a fault wipes the control and block-enable registers but leaves the flag set.

Top module: `flash_guard`

## Requirements
- R1: After the pin reset (`rst_n` low), all enables are low, `faultFlag` is low and every register reads back as zero.
- R2: A write to select 0 stores control bits [3:0] (bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify). `pgmEn`, `ersEn`, `pvfyEn` and `evfyEn` follow from the next cycle. Select 0 reads back these bits and select 2 reads back the block-enable register.
- R3: A control write with both bit0 and bit1 set is ignored entirely. A control write setting bit1 while the block-enable register is zero and no fault is present is ignored entirely. `pgmEn` and `ersEn` are never high together.
- R4: While control bit0 or bit1 is set, the fault flag rises on the next edge when any of these is high: `flashRd`, `busGrant`, `sleepExec`, `swStandby`, or `excEntry` without `excExempt`. With both bits clear, or for an exempt exception, no fault arises. The flag reads as bit0 of select 1.
- R5: In the cycle a fault event is seen, `pgmEn` and `ersEn` drop at once. The control and block-enable registers keep their contents.
- R6: While the fault flag is set, `pgmEn` and `ersEn` stay low, and control writes cannot change stored bits 0 and 1. Bits 2 and 3 are still written, and `pvfyEn`/`evfyEn` follow them.
- R7: The fault flag clears only on `rst_n` low, `wdtReset` or `hwStandby`; either of the last two also clears both registers. No other input clears it.
- R8: `swStandby` while the fault flag is set clears the control and block-enable registers to zero, ignores any same-cycle write, and keeps the flag set.
- R9: `nmiOut` follows `nmiIn` except while control bit0 or bit1 is set, when it is held low.
- R10: Writes to select 1 are ignored. The fault flag cannot be set or cleared from the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Pin reset, asynchronous, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 control, 1 status, 2 block enable |
| wrData | input | DATA_W | Write data |
| rdSel | input | 2 | Read target, same coding as wrSel, 3 reads zero |
| rdData | output | DATA_W | Read data |
| flashRd | input | 1 | CPU access (incl. fetch/vector) to the flash range under operation |
| excEntry | input | 1 | Exception handling entered |
| excExempt | input | 1 | Exception is an exempt kind (illegal reset, trap, divide by zero) |
| sleepExec | input | 1 | Sleep instruction executed |
| swStandby | input | 1 | Software standby entered |
| busGrant | input | 1 | Bus released to DMA, refresh or external master |
| wdtReset | input | 1 | Watchdog reset |
| hwStandby | input | 1 | Hardware standby |
| nmiIn | input | 1 | Raw non-maskable interrupt |
| pgmEn | output | 1 | Program enable to flash macro |
| ersEn | output | 1 | Erase enable to flash macro |
| pvfyEn | output | 1 | Program-verify enable |
| evfyEn | output | 1 | Erase-verify enable |
| nmiOut | output | 1 | Masked NMI to the CPU |
| faultFlag | output | 1 | Sticky fault flag |

## Verification
The assertions cover the properties that hold on every cycle:
- Program and erase are exclusive, and both are off under a fault or a fault event.
- The flag is sticky unless a watchdog or hardware-standby clear arrives, and it always clears after one.
- Every rise of the flag has a fault cause one cycle earlier.
- NMI is masked during a run.

The bench scenarios are needed for the rest:
- Register contents are retained across an abort.
- Verify bits stay writable under a fault.
- Illegal writes are dropped.
- Software standby wipes the registers.
- Exempt exceptions and idle-time events are ignored.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CTRL_W   = 4;
  localparam int PGM_BIT  = 0;
  localparam int ERS_BIT  = 1;
  localparam int PVFY_BIT = 2;
  localparam int EVFY_BIT = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BLK  = 2'd2;

  typedef struct packed {
    logic wrCtrl;   // store a control write
    logic keepRun;  // protect run bits during that write
    logic wrBlk;    // store a block-enable write
    logic abort;    // fault event this cycle
    logic clrAll;   // watchdog reset or hardware standby
    logic clrSoft;  // software standby under fault
  } guardStrobe_t;
endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic         wrPgm,
  input  logic         wrErs,
  input  logic         runActive,
  input  logic         blkAny,
  input  logic         flashRd,
  input  logic         excEntry,
  input  logic         excExempt,
  input  logic         sleepExec,
  input  logic         swStandby,
  input  logic         busGrant,
  input  logic         wdtReset,
  input  logic         hwStandby,
  output guardStrobe_t strobe,
  output logic         faultQ
);
  logic trip, clrAll, clrSoft, lockRun, ctrlLegal, eraseNoBlk;

  always_comb begin
    trip       = runActive & (flashRd | (excEntry & ~excExempt) | sleepExec
                              | swStandby | busGrant);
    clrAll     = wdtReset | hwStandby;
    clrSoft    = ~clrAll & faultQ & swStandby;
    lockRun    = faultQ | trip;
    ctrlLegal  = wrEn & (wrSel == SEL_CTRL) & ~clrAll & ~clrSoft & ~(wrPgm & wrErs);
    eraseNoBlk = wrErs & ~blkAny & ~lockRun;

    strobe.wrCtrl  = ctrlLegal & ~eraseNoBlk;
    strobe.keepRun = lockRun;
    strobe.wrBlk   = wrEn & (wrSel == SEL_BLK) & ~clrAll & ~clrSoft;
    strobe.abort   = trip;
    strobe.clrAll  = clrAll;
    strobe.clrSoft = clrSoft;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      faultQ <= 1'b0;
    else if (clrAll) faultQ <= 1'b0;
    else if (trip)   faultQ <= 1'b1;
  end
endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  guardStrobe_t      strobe,
  input  logic              faultQ,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  input  logic              nmiIn,
  output logic [DATA_W-1:0] rdData,
  output logic              runActive,
  output logic              blkAny,
  output logic              pgmEn,
  output logic              ersEn,
  output logic              pvfyEn,
  output logic              evfyEn,
  output logic              nmiOut
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [BLK_W-1:0]  blkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ <= '0;
      blkQ  <= '0;
    end else if (strobe.clrAll || strobe.clrSoft) begin
      ctrlQ <= '0;
      blkQ  <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        if (strobe.keepRun)
          ctrlQ <= {wrData[EVFY_BIT], wrData[PVFY_BIT], ctrlQ[ERS_BIT], ctrlQ[PGM_BIT]};
        else
          ctrlQ <= wrData[CTRL_W-1:0];
      end
      if (strobe.wrBlk) blkQ <= wrData[BLK_W-1:0];
    end
  end

  always_comb begin
    runActive = ctrlQ[PGM_BIT] | ctrlQ[ERS_BIT];
    blkAny    = |blkQ;
    pgmEn     = ctrlQ[PGM_BIT] & ~faultQ & ~strobe.abort;
    ersEn     = ctrlQ[ERS_BIT] & ~faultQ & ~strobe.abort;
    pvfyEn    = ctrlQ[PVFY_BIT];
    evfyEn    = ctrlQ[EVFY_BIT];
    nmiOut    = nmiIn & ~runActive;
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_CTRL: rdData[CTRL_W-1:0] = ctrlQ;
      SEL_STAT: rdData[0]          = faultQ;
      SEL_BLK:  rdData[BLK_W-1:0]  = blkQ;
      default:  rdData             = '0;
    endcase
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              flashRd,
  input  logic              excEntry,
  input  logic              excExempt,
  input  logic              sleepExec,
  input  logic              swStandby,
  input  logic              busGrant,
  input  logic              wdtReset,
  input  logic              hwStandby,
  input  logic              nmiIn,
  output logic              pgmEn,
  output logic              ersEn,
  output logic              pvfyEn,
  output logic              evfyEn,
  output logic              nmiOut,
  output logic              faultFlag
);
  guardStrobe_t strobe;
  logic faultQ, runActive, blkAny;

  flash_guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel),
    .wrPgm(wrData[PGM_BIT]), .wrErs(wrData[ERS_BIT]),
    .runActive(runActive), .blkAny(blkAny),
    .flashRd(flashRd), .excEntry(excEntry), .excExempt(excExempt),
    .sleepExec(sleepExec), .swStandby(swStandby), .busGrant(busGrant),
    .wdtReset(wdtReset), .hwStandby(hwStandby),
    .strobe(strobe), .faultQ(faultQ)
  );

  flash_guard_dp #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .faultQ(faultQ),
    .wrData(wrData), .rdSel(rdSel), .nmiIn(nmiIn), .rdData(rdData),
    .runActive(runActive), .blkAny(blkAny),
    .pgmEn(pgmEn), .ersEn(ersEn), .pvfyEn(pvfyEn), .evfyEn(evfyEn),
    .nmiOut(nmiOut)
  );

  assign faultFlag = faultQ;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic flashRd,
  input logic excEntry,
  input logic excExempt,
  input logic sleepExec,
  input logic swStandby,
  input logic busGrant,
  input logic wdtReset,
  input logic hwStandby,
  input logic pgmEn,
  input logic ersEn,
  input logic nmiOut,
  input logic faultFlag
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgmEn && ersEn));

  p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultFlag) |-> $past(flashRd || (excEntry && !excExempt) || sleepExec
                               || swStandby || busGrant));

  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flashRd || busGrant || sleepExec || swStandby || (excEntry && !excExempt))
      |-> (!pgmEn && !ersEn));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    faultFlag |-> (!pgmEn && !ersEn));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (faultFlag && !wdtReset && !hwStandby) |=> faultFlag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdtReset || hwStandby) |=> !faultFlag);

  p_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pgmEn || ersEn) |-> !nmiOut);
endmodule

bind flash_guard flash_guard_chk u_chk (.*);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int DATA_W = 8;
  localparam int BLK_W  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wrEn, flashRd, excEntry, excExempt, sleepExec, swStandby;
  logic busGrant, wdtReset, hwStandby, nmiIn;
  logic [1:0] wrSel, rdSel;
  logic [DATA_W-1:0] wrData, rdData;
  logic pgmEn, ersEn, pvfyEn, evfyEn, nmiOut, faultFlag;

  flash_guard #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u0 (.*);

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string tag = "R1";
  int mCtrl = 0, mBlk = 0, mFault = 0;

  function automatic bit modelEvent();
    return ((mCtrl & 3) != 0) && (flashRd || (excEntry && !excExempt) || sleepExec
                                  || swStandby || busGrant);
  endfunction

  task automatic cmp(string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step();
    bit ev;
    int expRd;
    #8;
    if (!rst_n) begin mCtrl = 0; mBlk = 0; mFault = 0; end
    ev = modelEvent();
    case (rdSel)
      2'd0: expRd = mCtrl;
      2'd1: expRd = mFault;
      2'd2: expRd = mBlk;
      default: expRd = 0;
    endcase
    cmp("pgmEn",  int'(pgmEn),  int'((mCtrl & 1) != 0 && mFault == 0 && !ev));
    cmp("ersEn",  int'(ersEn),  int'((mCtrl & 2) != 0 && mFault == 0 && !ev));
    cmp("pvfyEn", int'(pvfyEn), int'((mCtrl & 4) != 0));
    cmp("evfyEn", int'(evfyEn), int'((mCtrl & 8) != 0));
    cmp("nmiOut", int'(nmiOut), int'(nmiIn && (mCtrl & 3) == 0));
    cmp("faultFlag", int'(faultFlag), mFault);
    cmp("rdData", int'(rdData), expRd);
    @(posedge clk);
    if (!rst_n || wdtReset || hwStandby) begin
      mCtrl = 0; mBlk = 0; mFault = 0;
    end else begin
      if (mFault != 0 && swStandby) begin
        mCtrl = 0; mBlk = 0;
      end else if (wrEn) begin
        if (wrSel == 2'd0 && !(wrData[0] && wrData[1])) begin
          if (mFault != 0 || ev) mCtrl = (int'(wrData[3:0]) & 12) | (mCtrl & 3);
          else if (!(wrData[1] && mBlk == 0)) mCtrl = int'(wrData[3:0]);
        end else if (wrSel == 2'd2) begin
          mBlk = int'(wrData);
        end
      end
      if (ev) mFault = 1;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    wrEn = 0; flashRd = 0; excEntry = 0; excExempt = 0; sleepExec = 0;
    swStandby = 0; busGrant = 0; wdtReset = 0; hwStandby = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wrEn = 1; wrSel = sel; wrData = d; step(); wrEn = 0;
  endtask

  task automatic readAll();
    for (int s = 0; s < 4; s++) begin rdSel = 2'(s); step(); end
    rdSel = 2'd0;
  endtask

  initial begin
    rst_n = 0; wrSel = 0; wrData = 0; rdSel = 0; nmiIn = 1;
    quiet();
    @(negedge clk);
    tag = "R1"; step(); step();
    rst_n = 1;
    readAll();

    tag = "R2"; wr(2'd2, 8'h05); rdSel = 2'd2; step(); rdSel = 2'd0;
    tag = "R9"; wr(2'd0, 8'h01); step(); nmiIn = 0; step(); nmiIn = 1;
    tag = "R10"; wr(2'd1, 8'hFF); rdSel = 2'd1; step(); rdSel = 2'd0;

    tag = "R5"; flashRd = 1; step(); flashRd = 0;
    tag = "R4"; readAll();
    tag = "R6"; wr(2'd0, 8'h01); wr(2'd0, 8'h02); wr(2'd0, 8'h04); step();
    tag = "R7"; sleepExec = 1; step(); sleepExec = 0; busGrant = 1; step(); busGrant = 0;
    wr(2'd1, 8'h00); rdSel = 2'd1; step();
    wdtReset = 1; step(); wdtReset = 0; readAll();

    tag = "R3"; wr(2'd0, 8'h03); step(); wr(2'd0, 8'h02); step();
    wr(2'd2, 8'h80); wr(2'd0, 8'h03); wr(2'd0, 8'h02); step();
    tag = "R4"; excEntry = 1; excExempt = 1; step(); excEntry = 0; excExempt = 0; step();
    busGrant = 1; step(); busGrant = 0; rdSel = 2'd1; step(); rdSel = 2'd0;

    tag = "R8"; wr(2'd0, 8'h08); swStandby = 1; wrEn = 1; wrSel = 2'd2; wrData = 8'h33;
    step(); wrEn = 0; swStandby = 0; readAll();
    tag = "R7"; hwStandby = 1; step(); hwStandby = 0; readAll();

    tag = "R4"; flashRd = 1; step(); flashRd = 0; rdSel = 2'd1; step();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h01); excEntry = 1; step(); excEntry = 0; step();
    hwStandby = 1; step(); hwStandby = 0;
    wr(2'd0, 8'h02); sleepExec = 1; step(); sleepExec = 0; step();
    wdtReset = 1; step(); wdtReset = 0;
    wr(2'd0, 8'h01); swStandby = 1; step(); step(); swStandby = 0; readAll();

    tag = "R1"; rst_n = 0; step(); rst_n = 1; readAll();
    tag = "R2"; wr(2'd0, 8'h0C); readAll();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule